// File: doc/BRIEF.md
# DDR2 Command Sequencing Guard

The guard sits between the command issue stage of a memory controller and the pins of a DDR2 device. Each cycle it looks at the command being offered: activate, read, write, precharge or load-mode. It checks that command against the open/idle state of each bank and against three recovery windows. These are activate-to-access on the same bank, activate-to-activate across banks, and the quiet time after a mode-register load. A legal command is granted in the same cycle. An illegal one is stalled: grant drops and nothing inside the guard changes.

The first illegal command since reset sets a sticky violation flag and stores a 3-bit cause. Both hold until the next reset. The delay windows are parameters given in picoseconds together with the clock period. At elaboration they are turned into cycle counts by rounding the ratio up to the next whole cycle. For example, 20000 ps at 3750 ps per clock becomes 6 cycles. Mode-register loads must find every bank idle and no burst running. They must also leave the reserved address and bank bits at zero.

Top module: `cmd_seq_guard`

## Requirements
- R1: After a synchronous active-high reset, every bank is idle, `viol_flag` is 0, `viol_code` is 0, and `grant` is 1 while `cmd_valid` is 0.
- R2: A READ (op 2) or WRITE (op 3) to a bank with no open row is stalled (`grant`=0), with cause code 1.
- R3: After a granted ACTIVATE (op 1) at cycle t, a READ or WRITE to that bank is stalled with cause code 2 before cycle t+ceil(TRCD_PS/CLK_PS), and it is granted from that cycle on. With the defaults this is 6 cycles.
- R4: An ACTIVATE earlier than ceil(TRRD_PS/CLK_PS) cycles after the previous granted ACTIVATE is stalled with cause code 3. With the defaults this is 2 cycles. At exactly that distance it is granted.
- R5: An ACTIVATE to a bank whose row is already open is stalled with cause code 7.
- R6: PRECHARGE (op 4) is always granted outside the mode-load window, and it returns the bank to idle, so a following READ to that bank gets cause code 1.
- R7: LOAD MODE (op 5) is stalled with cause code 4 while any bank is open or `burst_busy` is 1.
- R8: For TMRD_CK cycles after a granted LOAD MODE, every command op 1 to 5 is stalled with cause code 5. The default is 2 cycles.
- R9: In a LOAD MODE, `cmd_ba[1:0]` picks the register (0 main, 1, 2, 3 extended). The load is stalled with cause code 6 if `cmd_ba[2]` is 1, if any of `cmd_addr[15:13]` is set, or if it targets register 3 and any of `cmd_addr[12:0]` is set. Other mode values are granted.
- R10: A stalled command leaves the bank state and the delay windows unchanged.
- R11: The first stall after reset sets `viol_flag` and stores its cause in `viol_code`. Later stalls do not change either, and only reset clears them.
- R12: Op codes 0, 6 and 7 are not commands. They are always granted and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 3 | Command code: 1 activate, 2 read, 3 write, 4 precharge, 5 load mode |
| cmd_ba | input | 3 | Bank address; bit 2 is reserved and only checked on load mode |
| cmd_addr | input | 16 | Row, column or mode value |
| burst_busy | input | 1 | A data burst is in flight |
| grant | output | 1 | 1 = command accepted, 0 = stalled |
| viol_flag | output | 1 | Sticky: a stall has occurred since reset |
| viol_code | output | 3 | Cause of the first stall |

## Verification
The assertions assume that `cmd_op` and `cmd_ba` are known whenever `cmd_valid` is high. They also assume that reset is held for at least one edge before the first command. The bench drives every input on the falling edge, and during reset it keeps `cmd_valid` low. The recovery-window properties count cycles since the last granted activate or load. They therefore also assume that the upstream logic does not count a stalled command as issued. The bench models this by treating every stalled command as discarded.

// File: rtl/cmd_guard_pkg.sv
package cmd_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_LMR = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    RS_NONE     = 3'd0,
    RS_NO_ROW   = 3'd1,
    RS_RCD      = 3'd2,
    RS_RRD      = 3'd3,
    RS_BUSY     = 3'd4,
    RS_MRD      = 3'd5,
    RS_RSVD     = 3'd6,
    RS_ROW_OPEN = 3'd7
  } reason_e;

  // Convert a time limit to whole clocks, rounding up.
  function automatic int unsigned ps_to_cycles(int unsigned lim_ps, int unsigned clk_ps);
    return (lim_ps + clk_ps - 1) / clk_ps;
  endfunction

  // Value loaded into a down-counter so that it reaches zero after n cycles.
  function automatic int unsigned window_load(int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic logic op_is_cmd(logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

endpackage

// File: rtl/gd_countdown.sv
module gd_countdown #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/gd_bank_table.sv
module gd_bank_table #(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_set,
  input  logic              close_set,
  input  logic [BANK_W-1:0] sel,
  output logic [NB-1:0]     is_open
);
  for (genvar i = 0; i < NB; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        is_open[i] <= 1'b0;
      else if (open_set && sel == BANK_W'(i))
        is_open[i] <= 1'b1;
      else if (close_set && sel == BANK_W'(i))
        is_open[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gd_rules.sv
module gd_rules
  import cmd_guard_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int BA_W   = 3,
  parameter int ADDR_W = 16,
  parameter int MODE_W = 13
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BA_W-1:0]   cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              burst_busy,
  input  logic [NB-1:0]     bank_open,
  input  logic [NB-1:0]     rcd_busy,
  input  logic              rrd_busy,
  input  logic              mrd_busy,
  output logic              ok,
  output reason_e           why
);
  logic [BANK_W-1:0] bank;
  logic              rsvd_bad;

  assign bank = cmd_ba[BANK_W-1:0];

  // Reserved-bit rule for mode loads; register 3 must be all zero.
  function automatic logic mode_reserved(logic [BA_W-1:0] ba, logic [ADDR_W-1:0] a);
    logic bad;
    bad = ba[BA_W-1] | (|a[ADDR_W-1:MODE_W]);
    if (ba[1:0] == 2'b11) bad = bad | (|a[MODE_W-1:0]);
    return bad;
  endfunction

  assign rsvd_bad = mode_reserved(cmd_ba, cmd_addr);

  always_comb begin
    ok  = 1'b1;
    why = RS_NONE;
    if (cmd_valid && op_is_cmd(cmd_op)) begin
      if (mrd_busy) begin
        ok = 1'b0; why = RS_MRD;
      end else begin
        case (op_e'(cmd_op))
          OP_ACT: begin
            if (bank_open[bank])  begin ok = 1'b0; why = RS_ROW_OPEN; end
            else if (rrd_busy)    begin ok = 1'b0; why = RS_RRD;      end
          end
          OP_RD, OP_WR: begin
            if (!bank_open[bank]) begin ok = 1'b0; why = RS_NO_ROW;   end
            else if (rcd_busy[bank]) begin ok = 1'b0; why = RS_RCD;   end
          end
          OP_LMR: begin
            if ((|bank_open) || burst_busy) begin ok = 1'b0; why = RS_BUSY; end
            else if (rsvd_bad)    begin ok = 1'b0; why = RS_RSVD;     end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_seq_guard.sv
module cmd_seq_guard
  import cmd_guard_pkg::*;
#(
  parameter int NB       = 4,
  parameter int ADDR_W   = 16,
  parameter int MODE_W   = 13,
  parameter int CLK_PS   = 3750,
  parameter int TRCD_PS  = 20000,
  parameter int TRRD_PS  = 7500,
  parameter int TMRD_CK  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(NB):0]       cmd_ba,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic                      burst_busy,
  output logic                      grant,
  output logic                      viol_flag,
  output logic [2:0]                viol_code
);
  localparam int BANK_W = $clog2(NB);
  localparam int BA_W   = BANK_W + 1;
  localparam int RCD_CK = ps_to_cycles(TRCD_PS, CLK_PS);
  localparam int RRD_CK = ps_to_cycles(TRRD_PS, CLK_PS);
  localparam int RCD_LD = window_load(RCD_CK);
  localparam int RRD_LD = window_load(RRD_CK);
  localparam int MRD_LD = window_load(TMRD_CK);
  localparam int MAX_LD = (RCD_LD > RRD_LD) ? ((RCD_LD > MRD_LD) ? RCD_LD : MRD_LD)
                                            : ((RRD_LD > MRD_LD) ? RRD_LD : MRD_LD);
  localparam int CW     = (MAX_LD < 2) ? 1 : $clog2(MAX_LD + 1);

  // Named internal events.
  logic [BANK_W-1:0] cmd_bank;
  logic [NB-1:0]     bank_open;
  logic [NB-1:0]     rcd_busy;
  logic              rrd_busy, mrd_busy;
  logic              ok;
  reason_e           why;
  logic              act_go, pre_go, lmr_go, stall_ev;

  assign cmd_bank = cmd_ba[BANK_W-1:0];

  gd_rules #(
    .NB(NB), .BANK_W(BANK_W), .BA_W(BA_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W)
  ) u_rules (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ba    (cmd_ba),
    .cmd_addr  (cmd_addr),
    .burst_busy(burst_busy),
    .bank_open (bank_open),
    .rcd_busy  (rcd_busy),
    .rrd_busy  (rrd_busy),
    .mrd_busy  (mrd_busy),
    .ok        (ok),
    .why       (why)
  );

  assign act_go   = cmd_valid && ok && (cmd_op == OP_ACT);
  assign pre_go   = cmd_valid && ok && (cmd_op == OP_PRE);
  assign lmr_go   = cmd_valid && ok && (cmd_op == OP_LMR);
  assign stall_ev = cmd_valid && !ok;

  gd_bank_table #(.NB(NB), .BANK_W(BANK_W)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .open_set (act_go),
    .close_set(pre_go),
    .sel      (cmd_bank),
    .is_open  (bank_open)
  );

  for (genvar b = 0; b < NB; b++) begin : g_rcd
    gd_countdown #(.CW(CW)) u_rcd (
      .clk     (clk),
      .rst     (rst),
      .load    (act_go && cmd_bank == BANK_W'(b)),
      .load_val(CW'(RCD_LD)),
      .busy    (rcd_busy[b])
    );
  end

  gd_countdown #(.CW(CW)) u_rrd (
    .clk(clk), .rst(rst), .load(act_go), .load_val(CW'(RRD_LD)), .busy(rrd_busy)
  );

  gd_countdown #(.CW(CW)) u_mrd (
    .clk(clk), .rst(rst), .load(lmr_go), .load_val(CW'(MRD_LD)), .busy(mrd_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_flag <= 1'b0;
      viol_code <= RS_NONE;
    end else if (stall_ev && !viol_flag) begin
      viol_flag <= 1'b1;
      viol_code <= why;
    end
  end

  assign grant = !cmd_valid || ok;
endmodule

// File: rtl/cmd_seq_guard_chk.sv
module cmd_seq_guard_chk
  import cmd_guard_pkg::*;
#(
  parameter int NB      = 4,
  parameter int CLK_PS  = 3750,
  parameter int TRRD_PS = 7500,
  parameter int TMRD_CK = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [2:0]          cmd_op,
  input logic [$clog2(NB)-1:0] cmd_bank,
  input logic                burst_busy,
  input logic                grant,
  input logic                viol_flag,
  input logic [2:0]          viol_code,
  input logic [NB-1:0]       bank_open
);
  localparam int RRD_N = ps_to_cycles(TRRD_PS, CLK_PS);

  logic        is_cmd, acc_act, acc_lmr;
  logic        seen_act, seen_lmr;
  logic [15:0] since_act, since_lmr;

  assign is_cmd  = cmd_valid && op_is_cmd(cmd_op);
  assign acc_act = cmd_valid && grant && cmd_op == OP_ACT;
  assign acc_lmr = cmd_valid && grant && cmd_op == OP_LMR;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_act <= 1'b0; seen_lmr <= 1'b0;
      since_act <= '0;  since_lmr <= '0;
    end else begin
      if (acc_act) begin seen_act <= 1'b1; since_act <= 16'd1; end
      else if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
      if (acc_lmr) begin seen_lmr <= 1'b1; since_lmr <= 16'd1; end
      else if (since_lmr != 16'hFFFF) since_lmr <= since_lmr + 16'd1;
    end
  end

  p_row_before_access_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank] |-> !grant);

  p_rrd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    acc_act && seen_act |-> since_act >= 16'(RRD_N));

  p_lmr_idle_r7: assert property (@(posedge clk) disable iff (rst)
    acc_lmr |-> (bank_open == '0) && !burst_busy);

  p_mrd_gap_r8: assert property (@(posedge clk) disable iff (rst)
    is_cmd && grant && seen_lmr |-> since_lmr >= 16'(TMRD_CK));

  p_stall_flags_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !grant |=> viol_flag);

  p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> viol_flag && $stable(viol_code));

  p_noncmd_grant_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !op_is_cmd(cmd_op) |-> grant);
endmodule

bind cmd_seq_guard cmd_seq_guard_chk #(
  .NB(NB), .CLK_PS(CLK_PS), .TRRD_PS(TRRD_PS), .TMRD_CK(TMRD_CK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_bank  (cmd_bank),
  .burst_busy(burst_busy),
  .grant     (grant),
  .viol_flag (viol_flag),
  .viol_code (viol_code),
  .bank_open (bank_open)
);

// File: tb/cmd_seq_guard_tb.sv
`timescale 1ns/1ps
module cmd_seq_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_ba = 3'd0;
  logic [15:0] cmd_addr = 16'd0;
  logic        burst_busy = 1'b0;
  logic        grant, viol_flag;
  logic [2:0]  viol_code;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Expected windows, restated with real arithmetic.
  localparam int RCD_EXP = int'($ceil(20000.0 / 3750.0));

  always #10 clk = ~clk;

  cmd_seq_guard u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ba(cmd_ba),
    .cmd_addr(cmd_addr), .burst_busy(burst_busy), .grant(grant),
    .viol_flag(viol_flag), .viol_code(viol_code)
  );

  typedef struct packed {
    logic        rs;
    logic        vld;
    logic [2:0]  op;
    logic [2:0]  ba;
    logic [15:0] addr;
    logic        busy;
    logic        g;
    logic        f;
    logic [2:0]  c;
    logic [3:0]  req;
  } vec_t;

  function automatic vec_t mk(logic rs, logic vld, logic [2:0] op, logic [2:0] ba,
                              logic [15:0] addr, logic busy, logic g, logic f,
                              logic [2:0] c, logic [3:0] req);
    return '{rs, vld, op, ba, addr, busy, g, f, c, req};
  endfunction

  localparam int NV = 57;
  localparam vec_t VT [NV] = '{
    mk(0,0,0,0,16'h0000,0, 1,0,0, 1),  // 0  R1 idle
    mk(0,1,2,0,16'h0000,0, 0,0,0, 2),  // 1  R2 read, no row
    mk(0,0,0,0,16'h0000,0, 1,1,1, 11), // 2  R11 flag set
    mk(1,0,0,0,16'h0000,0, 1,1,1, 11), // 3  reset
    mk(0,1,1,0,16'h0005,0, 1,0,0, 3),  // 4  R3 act b0
    mk(0,1,2,0,16'h0000,0, 0,0,0, 3),  // 5  R3 too early
    mk(0,0,0,0,16'h0000,0, 1,1,2, 3),  // 6
    mk(1,0,0,0,16'h0000,0, 1,1,2, 11), // 7
    mk(0,1,1,1,16'h0010,0, 1,0,0, 4),  // 8  R4 act b1
    mk(0,1,1,2,16'h0011,0, 0,0,0, 4),  // 9  R4 act b2 too soon
    mk(0,0,0,0,16'h0000,0, 1,1,3, 4),  // 10
    mk(1,0,0,0,16'h0000,0, 1,1,3, 11), // 11
    mk(0,1,1,1,16'h0020,0, 1,0,0, 3),  // 12 act b1
    mk(0,0,0,0,16'h0000,0, 1,0,0, 3),  // 13
    mk(0,1,1,2,16'h0021,0, 1,0,0, 4),  // 14 R4 exactly at window
    mk(0,0,0,0,16'h0000,0, 1,0,0, 3),  // 15
    mk(0,0,0,0,16'h0000,0, 1,0,0, 3),  // 16
    mk(0,0,0,0,16'h0000,0, 1,0,0, 3),  // 17
    mk(0,1,2,1,16'h0004,0, 1,0,0, 3),  // 18 R3 read at t+6
    mk(0,1,3,1,16'h0008,0, 1,0,0, 3),  // 19 write
    mk(0,1,1,1,16'h0030,0, 0,0,0, 5),  // 20 R5 act open bank
    mk(0,0,0,0,16'h0000,0, 1,1,7, 5),  // 21
    mk(1,0,0,0,16'h0000,0, 1,1,7, 11), // 22
    mk(0,1,1,3,16'h0040,0, 1,0,0, 6),  // 23 act b3
    mk(0,1,4,3,16'h0000,0, 1,0,0, 6),  // 24 R6 precharge
    mk(0,1,2,3,16'h0000,0, 0,0,0, 6),  // 25 R6 read closed bank
    mk(0,0,0,0,16'h0000,0, 1,1,1, 6),  // 26
    mk(1,0,0,0,16'h0000,0, 1,1,1, 11), // 27
    mk(0,1,1,0,16'h0050,0, 1,0,0, 7),  // 28 act b0
    mk(0,0,0,0,16'h0000,0, 1,0,0, 7),  // 29
    mk(0,0,0,0,16'h0000,0, 1,0,0, 7),  // 30
    mk(0,1,5,0,16'h0000,0, 0,0,0, 7),  // 31 R7 load, bank open
    mk(0,0,0,0,16'h0000,0, 1,1,4, 7),  // 32
    mk(1,0,0,0,16'h0000,0, 1,1,4, 11), // 33
    mk(0,1,5,0,16'h0000,1, 0,0,0, 7),  // 34 R7 load during burst
    mk(0,0,0,0,16'h0000,0, 1,1,4, 7),  // 35
    mk(1,0,0,0,16'h0000,0, 1,1,4, 11), // 36
    mk(0,1,5,0,16'h0042,0, 1,0,0, 9),  // 37 R9 legal load
    mk(0,1,1,0,16'h0060,0, 0,0,0, 8),  // 38 R8 inside window
    mk(0,0,0,0,16'h0000,0, 1,1,5, 8),  // 39
    mk(0,1,1,0,16'h0061,0, 1,1,5, 10), // 40 R10 stalled act left b0 idle
    mk(0,1,2,0,16'h0000,0, 0,1,5, 11), // 41 R11 new stall, code kept
    mk(0,0,0,0,16'h0000,0, 1,1,5, 11), // 42
    mk(1,0,0,0,16'h0000,0, 1,1,5, 11), // 43
    mk(0,1,5,3,16'h0001,0, 0,0,0, 9),  // 44 R9 reg3 nonzero
    mk(0,0,0,0,16'h0000,0, 1,1,6, 9),  // 45
    mk(1,0,0,0,16'h0000,0, 1,1,6, 11), // 46
    mk(0,1,5,4,16'h0000,0, 0,0,0, 9),  // 47 R9 upper bank bit
    mk(0,0,0,0,16'h0000,0, 1,1,6, 9),  // 48
    mk(1,0,0,0,16'h0000,0, 1,1,6, 11), // 49
    mk(0,1,5,1,16'h2000,0, 0,0,0, 9),  // 50 R9 address bit 13
    mk(0,0,0,0,16'h0000,0, 1,1,6, 9),  // 51
    mk(1,0,0,0,16'h0000,0, 1,1,6, 11), // 52
    mk(0,1,5,3,16'h0000,0, 1,0,0, 9),  // 53 R9 reg3 all zero
    mk(0,1,6,0,16'h0000,0, 1,0,0, 12), // 54 R12 op 6 in window
    mk(0,1,7,2,16'h0000,0, 1,0,0, 12), // 55 R12 op 7
    mk(0,0,0,0,16'h0000,0, 1,0,0, 12)  // 56 R12 nothing flagged
  };

  task automatic chk(int req, string what, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic rs, logic vld, logic [2:0] op, logic [2:0] ba,
                       logic [15:0] addr, logic busy);
    @(negedge clk);
    rst = rs; cmd_valid = vld; cmd_op = op; cmd_ba = ba; cmd_addr = addr;
    burst_busy = busy;
    #1;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // R1: reset state
    drive(0,0,0,0,16'h0,0);
    chk(1, "grant after reset", {2'b0, grant}, 3'd1);
    chk(1, "flag after reset", {2'b0, viol_flag}, 3'd0);
    chk(1, "code after reset", viol_code, 3'd0);

    drive(1,0,0,0,16'h0,0);
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].rs, VT[i].vld, VT[i].op, VT[i].ba, VT[i].addr, VT[i].busy);
      chk(int'(VT[i].req), $sformatf("vec %0d grant", i), {2'b0, grant}, {2'b0, VT[i].g});
      chk(int'(VT[i].req), $sformatf("vec %0d flag", i), {2'b0, viol_flag}, {2'b0, VT[i].f});
      chk(int'(VT[i].req), $sformatf("vec %0d code", i), viol_code, VT[i].c);
    end

    // R3 directed: write one cycle short of the window, then at it.
    drive(1,0,0,0,16'h0,0);
    drive(0,1,1,2,16'h0123,0);
    for (int k = 1; k < RCD_EXP - 1; k++) drive(0,0,0,0,16'h0,0);
    drive(0,1,3,2,16'h0000,0);
    chk(3, "write one cycle early", {2'b0, grant}, 3'd0);
    drive(0,1,3,2,16'h0000,0);
    chk(3, "write at window", {2'b0, grant}, 3'd1);
    chk(3, "code from early write", viol_code, 3'd2);

    // R6 directed: precharge of an idle bank is granted.
    drive(1,0,0,0,16'h0,0);
    drive(0,1,4,1,16'h0,0);
    chk(6, "precharge idle bank", {2'b0, grant}, 3'd1);
    drive(0,0,0,0,16'h0,0);
    chk(6, "no flag after precharge", {2'b0, viol_flag}, 3'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule